// File: doc/BRIEF.md
# Self-Triggered Channel Hit Detector

This block sits in one readout channel. Each clock it takes one filtered 9-bit sample and decides whether the channel holds a hit. Three qualification schemes are available: a plain threshold, a two-level threshold, and a minimum run of samples above threshold. A hit can also come from either adjacent channel through two neighbor flags. This lets a channel that stays below threshold still be read out beside a real hit.

When a hit starts, the block opens a readout window and tags it with a 2-bit type code. It also captures the global 12-bit timestamp from the opening edge. While the channel qualifies a hit of its own, it pulses a one-bit flag toward its neighbors. The window stays open for a programmed minimum length and for as long as the signal stays above threshold. A hard maximum length caps it. A mask input silences the channel completely.

Top module: `chan_hit_detect`

## Requirements
- R1: While `rst_n` is low, every output is zero after the next clock edge, whatever the samples and neighbor flags are.
- R2: With `mode_i` 2'b00 (or the spare code 2'b11), a window opens at the edge of the first sample strictly greater than `thr_lo_i`, with type 2'b01.
- R3: With `mode_i` 2'b01, an excursion above `thr_lo_i` opens a window only at the first of its samples strictly greater than `thr_hi_i`. An excursion that never passes `thr_hi_i` gives no hit.
- R4: With `mode_i` 2'b10, a window opens at the edge of the N-th consecutive sample above `thr_lo_i`, where N is `qual_len_i` (0 counts as 1). Shorter runs give no hit.
- R5: Any bit of `nb_hit_i` (bit 0 and bit 1, one per adjacent channel) high while idle and unmasked opens a window at the next edge with type 2'b10, and `int_hit_o` stays low.
- R6: `hit_type_o` is 2'b00 whenever no window is open. Inside a window, bit 0 marks an internal trigger and bit 1 marks a neighbor trigger. Triggers that arrive later in the same window OR into the code, so both sources give 2'b11.
- R7: `hit_ts_o` takes the value of `ts_i` at the opening edge. It holds that value through the window and after it, until the next opening.
- R8: A window lasts at least `hit_len_i` cycles (0 counts as 1). It stays open while samples remain above `thr_lo_i`, and closes at the first edge where the count has reached `hit_len_i` and the sample is at or below `thr_lo_i`.
- R9: A window never stays open longer than `max_len_i` cycles (0 counts as 1). This bound wins over `hit_len_i`.
- R10: One excursion above `thr_lo_i` yields at most one internal trigger. After a window is closed by the maximum length, no new internal hit starts until a sample at or below `thr_lo_i` has been seen.
- R11: While `mask_i` is high, no window opens and `int_hit_o` stays low. Asserting it during a window closes the window at the next edge.
- R12: `int_hit_o` is a single-cycle pulse, one edge after the sample that qualifies an internal trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 9 | Filtered ADC sample, unsigned |
| mode_i | input | 2 | Qualification scheme: 00 single, 01 double, 10 run length, 11 as single |
| thr_lo_i | input | 9 | Main threshold |
| thr_hi_i | input | 9 | Confirmation threshold for the double scheme |
| qual_len_i | input | 6 | Required run length for the run-length scheme |
| hit_len_i | input | 6 | Minimum window length in cycles |
| max_len_i | input | 6 | Maximum window length in cycles |
| mask_i | input | 1 | Channel mask, high disables all hits |
| nb_hit_i | input | 2 | Trigger flags from the two adjacent channels |
| ts_i | input | 12 | Global timestamp |
| hit_active_o | output | 1 | High while the readout window is open |
| hit_type_o | output | 2 | Type code of the open window |
| hit_ts_o | output | 12 | Timestamp captured at window opening |
| int_hit_o | output | 1 | Internal-trigger flag toward the neighbors |

## Verification
The properties assume that the length and threshold settings stay fixed while a window is open. They also assume that neighbor flags are synchronous levels sampled once per cycle. The window-length bound is measured against the current `max_len_i`, so it holds only if that setting does not move mid-window. The stimulus changes configuration only after a stretch of zero samples with no neighbor activity, when the window is certainly closed. All inputs are driven on the falling clock edge.

// File: rtl/hd_pkg.sv
// Shared definitions for the channel hit detector.
// Holds the qualification scheme encoding and the hit type codes.
package hd_pkg;

    typedef enum logic [1:0] {
        TRIG_SINGLE = 2'b00,
        TRIG_DOUBLE = 2'b01,
        TRIG_RUNLEN = 2'b10,
        TRIG_SPARE  = 2'b11
    } trig_mode_e;

    localparam logic [1:0] HTYPE_IDLE  = 2'b00;
    localparam logic [1:0] HTYPE_SELF  = 2'b01;
    localparam logic [1:0] HTYPE_NEIGH = 2'b10;
    localparam logic [1:0] HTYPE_BOTH  = 2'b11;

endpackage

// File: rtl/hd_qualifier.sv
// Internal trigger qualifier.
// Looks at one sample per cycle and raises trig_o (combinational) on the
// sample that qualifies an excursion above thr_lo under the selected scheme.
// Only one trigger is given per excursion: a fired flag blocks further
// triggers until a sample at or below thr_lo is seen.
// Assumes the thresholds and the run length are quasi-static.
module hd_qualifier #(
    parameter int SMP_W = 9,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] sample_i,
    input  logic [1:0]       mode_i,
    input  logic [SMP_W-1:0] thr_lo_i,
    input  logic [SMP_W-1:0] thr_hi_i,
    input  logic [LEN_W-1:0] qual_len_i,
    output logic             above_o,
    output logic             trig_o
);
    import hd_pkg::*;

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    logic [LEN_W-1:0] run_q;
    logic [LEN_W-1:0] run_nx;
    logic [LEN_W-1:0] qlen_eff;
    logic             fired_q;
    trig_mode_e       mode;

    assign mode     = trig_mode_e'(mode_i);
    assign above_o  = (sample_i > thr_lo_i);
    assign qlen_eff = (qual_len_i == '0) ? LEN_ONE : qual_len_i;
    // run length including the current sample, saturating
    assign run_nx   = (&run_q) ? run_q : run_q + LEN_ONE;

    // Decide whether the current sample qualifies the excursion.
    always_comb begin
        trig_o = 1'b0;
        if (above_o && !fired_q) begin
            case (mode)
                TRIG_DOUBLE: trig_o = (sample_i > thr_hi_i);
                TRIG_RUNLEN: trig_o = (run_nx >= qlen_eff);
                default:     trig_o = 1'b1;
            endcase
        end
    end

    // Track the current excursion length and the one-shot flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            fired_q <= 1'b0;
        end else if (!above_o) begin
            run_q   <= '0;
            fired_q <= 1'b0;
        end else begin
            run_q <= run_nx;
            if (trig_o) begin
                fired_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hd_window.sv
// Readout window controller.
// Opens a window on an internal trigger or on any neighbor flag, counts its
// length, accumulates the hit type and closes it on the minimum-length /
// below-threshold rule, on the maximum length or on mask.
// Assumes window length settings do not change while a window is open.
module hd_window #(
    parameter int LEN_W = 6,
    parameter int NB_N  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             self_trig_i,
    input  logic             above_i,
    input  logic [NB_N-1:0]  nb_hit_i,
    input  logic             mask_i,
    input  logic [LEN_W-1:0] hit_len_i,
    input  logic [LEN_W-1:0] max_len_i,
    output logic             open_o,
    output logic             active_o,
    output logic [1:0]       type_o,
    output logic             int_hit_o
);
    import hd_pkg::*;

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    logic [NB_N-1:0]  nb_live;
    logic             nb_any;
    logic             trig_self;
    logic             close;
    logic [1:0]       src_code;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] hl_eff;
    logic [LEN_W-1:0] ml_eff;
    logic             act_q;
    logic [1:0]       type_q;
    logic             ih_q;

    // Gate each neighbor flag with the mask.
    for (genvar g = 0; g < NB_N; g++) begin : g_nb
        assign nb_live[g] = nb_hit_i[g] & ~mask_i;
    end

    assign nb_any    = |nb_live;
    assign trig_self = self_trig_i & ~mask_i;
    assign src_code  = (nb_any ? HTYPE_NEIGH : HTYPE_IDLE) |
                       (trig_self ? HTYPE_SELF : HTYPE_IDLE);
    assign hl_eff    = (hit_len_i == '0) ? LEN_ONE : hit_len_i;
    assign ml_eff    = (max_len_i == '0) ? LEN_ONE : max_len_i;
    assign open_o    = !act_q && (src_code != HTYPE_IDLE);
    assign close     = act_q && (mask_i || (cnt_q >= ml_eff) ||
                                 ((cnt_q >= hl_eff) && !above_i));

    // Window state, length count and accumulated type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            cnt_q  <= '0;
            type_q <= HTYPE_IDLE;
        end else if (open_o) begin
            act_q  <= 1'b1;
            cnt_q  <= LEN_ONE;
            type_q <= src_code;
        end else if (close) begin
            act_q  <= 1'b0;
            cnt_q  <= '0;
            type_q <= HTYPE_IDLE;
        end else if (act_q) begin
            cnt_q  <= cnt_q + LEN_ONE;
            type_q <= type_q | src_code;
        end
    end

    // One-cycle internal-hit pulse toward the neighbors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ih_q <= 1'b0;
        end else begin
            ih_q <= trig_self;
        end
    end

    assign active_o  = act_q;
    assign type_o    = type_q;
    assign int_hit_o = ih_q;

endmodule

// File: rtl/hd_stamp.sv
// Timestamp capture register.
// Loads the global timestamp on the cycle a window opens and holds it
// otherwise. Assumes ts_i is synchronous to clk.
module hd_stamp #(
    parameter int TS_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [TS_W-1:0] ts_i,
    output logic [TS_W-1:0] ts_o
);

    logic [TS_W-1:0] ts_q;

    // Capture on window opening.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else if (load_i) begin
            ts_q <= ts_i;
        end
    end

    assign ts_o = ts_q;

endmodule

// File: rtl/chan_hit_detect.sv
// Self-triggered channel hit detector (top).
// Joins the qualifier, the window controller and the timestamp register.
// Outputs are registered and follow the triggering sample by one edge.
// Assumes one sample per clock and inputs synchronous to clk.
module chan_hit_detect #(
    parameter int SMP_W = 9,
    parameter int LEN_W = 6,
    parameter int TS_W  = 12,
    parameter int NB_N  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] sample_i,
    input  logic [1:0]       mode_i,
    input  logic [SMP_W-1:0] thr_lo_i,
    input  logic [SMP_W-1:0] thr_hi_i,
    input  logic [LEN_W-1:0] qual_len_i,
    input  logic [LEN_W-1:0] hit_len_i,
    input  logic [LEN_W-1:0] max_len_i,
    input  logic             mask_i,
    input  logic [NB_N-1:0]  nb_hit_i,
    input  logic [TS_W-1:0]  ts_i,
    output logic             hit_active_o,
    output logic [1:0]       hit_type_o,
    output logic [TS_W-1:0]  hit_ts_o,
    output logic             int_hit_o
);

    logic above;
    logic self_trig;
    logic win_open;

    hd_qualifier #(.SMP_W(SMP_W), .LEN_W(LEN_W)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (sample_i),
        .mode_i     (mode_i),
        .thr_lo_i   (thr_lo_i),
        .thr_hi_i   (thr_hi_i),
        .qual_len_i (qual_len_i),
        .above_o    (above),
        .trig_o     (self_trig)
    );

    hd_window #(.LEN_W(LEN_W), .NB_N(NB_N)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .self_trig_i (self_trig),
        .above_i     (above),
        .nb_hit_i    (nb_hit_i),
        .mask_i      (mask_i),
        .hit_len_i   (hit_len_i),
        .max_len_i   (max_len_i),
        .open_o      (win_open),
        .active_o    (hit_active_o),
        .type_o      (hit_type_o),
        .int_hit_o   (int_hit_o)
    );

    hd_stamp #(.TS_W(TS_W)) u_stamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (win_open),
        .ts_i   (ts_i),
        .ts_o   (hit_ts_o)
    );

endmodule

// File: rtl/chan_hit_detect_chk.sv
// Property checker for the channel hit detector, bound to the top.
// Sees only top-level ports. Assumes length settings are static during a window.
module chan_hit_detect_chk #(
    parameter int LEN_W = 6,
    parameter int TS_W  = 12,
    parameter int NB_N  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LEN_W-1:0] max_len_i,
    input logic             mask_i,
    input logic [NB_N-1:0]  nb_hit_i,
    input logic [TS_W-1:0]  ts_i,
    input logic             hit_active_o,
    input logic [1:0]       hit_type_o,
    input logic [TS_W-1:0]  hit_ts_o,
    input logic             int_hit_o
);

    logic [LEN_W:0] act_run;
    logic [LEN_W:0] ml_bound;

    assign ml_bound = (max_len_i == '0) ? (LEN_W+1)'(1) : {1'b0, max_len_i};

    // Count the active cycles already seen in the current window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_run <= '0;
        end else if (hit_active_o) begin
            act_run <= act_run + (LEN_W+1)'(1);
        end else begin
            act_run <= '0;
        end
    end

    a_r11_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |=> (!hit_active_o && !int_hit_o));

    a_r6_idle_type: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_active_o |-> (hit_type_o == 2'b00));

    a_r6_active_type: assert property (@(posedge clk) disable iff (!rst_n)
        hit_active_o |-> (hit_type_o != 2'b00));

    a_r7_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hit_active_o |=> (!hit_active_o || $stable(hit_ts_o)));

    a_r7_ts_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_active_o && !mask_i && (|nb_hit_i)) |=> (hit_ts_o == $past(ts_i)));

    a_r5_nb_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_active_o && !mask_i && (|nb_hit_i)) |=> (hit_active_o && hit_type_o[1]));

    a_r12_int_single: assert property (@(posedge clk) disable iff (!rst_n)
        int_hit_o |=> !int_hit_o);

    a_r9_max_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hit_active_o |-> (act_run < ml_bound));

endmodule

bind chan_hit_detect chan_hit_detect_chk #(
    .LEN_W (LEN_W),
    .TS_W  (TS_W),
    .NB_N  (NB_N)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .max_len_i    (max_len_i),
    .mask_i       (mask_i),
    .nb_hit_i     (nb_hit_i),
    .ts_i         (ts_i),
    .hit_active_o (hit_active_o),
    .hit_type_o   (hit_type_o),
    .hit_ts_o     (hit_ts_o),
    .int_hit_o    (int_hit_o)
);

// File: tb/chan_hit_detect_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected outputs for each applied
// cycle, and the monitor pops and compares them 1 ns after the next rising edge.
module chan_hit_detect_tb;

    typedef struct {
        logic        act;
        logic [1:0]  typ;
        logic        ih;
        logic [11:0] ts;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  smp = '0;
    logic [1:0]  mode = 2'b00;
    logic [8:0]  thr_lo = 9'd100;
    logic [8:0]  thr_hi = 9'd200;
    logic [5:0]  qlen = 6'd3;
    logic [5:0]  hlen = 6'd3;
    logic [5:0]  mlen = 6'd5;
    logic        mask = 1'b0;
    logic [1:0]  nb = 2'b00;
    logic [11:0] ts_in = '0;
    logic        act_o;
    logic [1:0]  typ_o;
    logic [11:0] ts_o;
    logic        ih_o;

    exp_t        sb[$];
    logic [11:0] ts_ctr = '0;
    logic [11:0] exp_ts = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    chan_hit_detect u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_i     (smp),
        .mode_i       (mode),
        .thr_lo_i     (thr_lo),
        .thr_hi_i     (thr_hi),
        .qual_len_i   (qlen),
        .hit_len_i    (hlen),
        .max_len_i    (mlen),
        .mask_i       (mask),
        .nb_hit_i     (nb),
        .ts_i         (ts_in),
        .hit_active_o (act_o),
        .hit_type_o   (typ_o),
        .hit_ts_o     (ts_o),
        .int_hit_o    (ih_o)
    );

    // Apply one cycle of input and queue the outputs expected after the edge.
    task automatic step(input logic [8:0] s, input logic [1:0] n, input logic m,
                        input logic opens, input logic ea, input logic [1:0] et,
                        input logic ei, input string tag);
        exp_t e;
        @(negedge clk);
        ts_ctr = ts_ctr + 12'd37;
        smp    = s;
        nb     = n;
        mask   = m;
        ts_in  = ts_ctr;
        if (opens) exp_ts = ts_ctr;
        e.act = ea;
        e.typ = et;
        e.ih  = ei;
        e.ts  = exp_ts;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(9'd0, 2'b00, 1'b0, 0, 0, 2'b00, 0, tag);
    endtask

    // Monitor: compare outputs against the oldest queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (act_o !== e.act || typ_o !== e.typ || ih_o !== e.ih || ts_o !== e.ts) begin
                    n_fail++;
                    $display("FAIL %s: act=%0b type=%b int=%0b ts=%0d expected act=%0b type=%b int=%0b ts=%0d",
                             e.tag, act_o, typ_o, ih_o, ts_o, e.act, e.typ, e.ih, e.ts);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: act=%0b expected run to complete", act_o);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset holds everything at zero
        step(9'd300, 2'b11, 0, 0, 0, 2'b00, 0, "R1");
        step(9'd0,   2'b00, 0, 0, 0, 2'b00, 0, "R1");
        rst_n = 1'b1;
        idle(2, "R1");

        // R2 R8 R12: single threshold, minimum length 3
        step(9'd150, 2'b00, 0, 1, 1, 2'b01, 1, "R2");
        step(9'd150, 2'b00, 0, 0, 1, 2'b01, 0, "R12");
        step(9'd50,  2'b00, 0, 0, 1, 2'b01, 0, "R8");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R8");
        idle(1, "R8");

        // R8: window extended while above threshold
        step(9'd150, 2'b00, 0, 1, 1, 2'b01, 1, "R8");
        step(9'd150, 2'b00, 0, 0, 1, 2'b01, 0, "R8");
        step(9'd150, 2'b00, 0, 0, 1, 2'b01, 0, "R8");
        step(9'd150, 2'b00, 0, 0, 1, 2'b01, 0, "R8");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R8");
        idle(1, "R8");

        // R9 R10: max length closes a long pulse, no retrigger until below
        step(9'd150, 2'b00, 0, 1, 1, 2'b01, 1, "R9");
        step(9'd150, 2'b00, 0, 0, 1, 2'b01, 0, "R9");
        step(9'd150, 2'b00, 0, 0, 1, 2'b01, 0, "R9");
        step(9'd150, 2'b00, 0, 0, 1, 2'b01, 0, "R9");
        step(9'd150, 2'b00, 0, 0, 1, 2'b01, 0, "R9");
        step(9'd150, 2'b00, 0, 0, 0, 2'b00, 0, "R9");
        step(9'd150, 2'b00, 0, 0, 0, 2'b00, 0, "R10");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R10");
        step(9'd150, 2'b00, 0, 1, 1, 2'b01, 1, "R10");
        step(9'd50,  2'b00, 0, 0, 1, 2'b01, 0, "R10");
        step(9'd50,  2'b00, 0, 0, 1, 2'b01, 0, "R10");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R10");
        idle(1, "R9");

        // R9: max length below min length wins
        hlen = 6'd6; mlen = 6'd2;
        step(9'd150, 2'b00, 0, 1, 1, 2'b01, 1, "R9");
        step(9'd50,  2'b00, 0, 0, 1, 2'b01, 0, "R9");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R9");
        idle(1, "R9");
        hlen = 6'd3; mlen = 6'd5;

        // R3: double threshold
        mode = 2'b01;
        step(9'd150, 2'b00, 0, 0, 0, 2'b00, 0, "R3");
        step(9'd180, 2'b00, 0, 0, 0, 2'b00, 0, "R3");
        step(9'd150, 2'b00, 0, 0, 0, 2'b00, 0, "R3");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R3");
        step(9'd150, 2'b00, 0, 0, 0, 2'b00, 0, "R3");
        step(9'd250, 2'b00, 0, 1, 1, 2'b01, 1, "R3");
        step(9'd150, 2'b00, 0, 0, 1, 2'b01, 0, "R3");
        step(9'd50,  2'b00, 0, 0, 1, 2'b01, 0, "R3");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R3");
        idle(1, "R3");

        // R4: run-length qualification, N = 3
        mode = 2'b10;
        step(9'd150, 2'b00, 0, 0, 0, 2'b00, 0, "R4");
        step(9'd150, 2'b00, 0, 0, 0, 2'b00, 0, "R4");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R4");
        step(9'd150, 2'b00, 0, 0, 0, 2'b00, 0, "R4");
        step(9'd150, 2'b00, 0, 0, 0, 2'b00, 0, "R4");
        step(9'd150, 2'b00, 0, 1, 1, 2'b01, 1, "R4");
        step(9'd50,  2'b00, 0, 0, 1, 2'b01, 0, "R4");
        step(9'd50,  2'b00, 0, 0, 1, 2'b01, 0, "R4");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R4");
        idle(1, "R4");
        // R4: N = 0 acts as 1
        qlen = 6'd0;
        step(9'd150, 2'b00, 0, 1, 1, 2'b01, 1, "R4");
        step(9'd50,  2'b00, 0, 0, 1, 2'b01, 0, "R4");
        step(9'd50,  2'b00, 0, 0, 1, 2'b01, 0, "R4");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R4");
        idle(1, "R4");
        qlen = 6'd3;

        // R2: spare mode code behaves as single threshold
        mode = 2'b11;
        step(9'd150, 2'b00, 0, 1, 1, 2'b01, 1, "R2");
        step(9'd50,  2'b00, 0, 0, 1, 2'b01, 0, "R2");
        step(9'd50,  2'b00, 0, 0, 1, 2'b01, 0, "R2");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R2");
        idle(1, "R2");
        mode = 2'b00;

        // R5: left and right neighbor flags
        step(9'd0, 2'b01, 0, 1, 1, 2'b10, 0, "R5");
        step(9'd0, 2'b00, 0, 0, 1, 2'b10, 0, "R5");
        step(9'd0, 2'b00, 0, 0, 1, 2'b10, 0, "R5");
        step(9'd0, 2'b00, 0, 0, 0, 2'b00, 0, "R5");
        step(9'd0, 2'b10, 0, 1, 1, 2'b10, 0, "R5");
        step(9'd0, 2'b00, 0, 0, 1, 2'b10, 0, "R7");
        step(9'd0, 2'b00, 0, 0, 1, 2'b10, 0, "R7");
        step(9'd0, 2'b00, 0, 0, 0, 2'b00, 0, "R7");

        // R6: late internal trigger ORs into a neighbor window
        step(9'd0,   2'b01, 0, 1, 1, 2'b10, 0, "R6");
        step(9'd150, 2'b00, 0, 0, 1, 2'b11, 1, "R6");
        step(9'd50,  2'b00, 0, 0, 1, 2'b11, 0, "R6");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R6");
        // R6: simultaneous sources
        step(9'd150, 2'b10, 0, 1, 1, 2'b11, 1, "R6");
        step(9'd50,  2'b00, 0, 0, 1, 2'b11, 0, "R6");
        step(9'd50,  2'b00, 0, 0, 1, 2'b11, 0, "R6");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R6");
        idle(1, "R6");

        // R11: mask blocks opening and closes an open window
        step(9'd150, 2'b11, 1, 0, 0, 2'b00, 0, "R11");
        step(9'd150, 2'b11, 1, 0, 0, 2'b00, 0, "R11");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R11");
        step(9'd150, 2'b00, 0, 1, 1, 2'b01, 1, "R11");
        step(9'd150, 2'b00, 1, 0, 0, 2'b00, 0, "R11");
        step(9'd50,  2'b00, 0, 0, 0, 2'b00, 0, "R11");
        idle(2, "R11");

        @(negedge clk);
        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule